// File: doc/BRIEF.md
# Aligned PWM Channel Comparator

This block generates one pulse-width-modulated output. An internal counter is compared all the time against a programmed period and a programmed duty value, and the output level follows from those comparisons. The duty value sets the length of the inactive part of each period, so the active time is the period minus the duty. A mode input selects edge-aligned operation, where the counter only counts up. It can also select symmetric operation, where the counter counts up and then back down, which doubles the period and centres the active window.

The counter advances on a selectable clock enable. The choices are eleven power-of-two divisions of the master clock, produced by a free-running prescaler, or one of two divided-clock enables supplied from outside. All logic runs on the master clock. New period, duty and mode values take effect only at a period boundary, and a single-cycle event pulse marks each boundary. When the channel is disabled, its counter is held at zero and the output is inactive.

Top module: `pwm_aligned_channel`

## Requirements
- R1: While reset is held and in the first cycle after it, `pwm_o` and `evt_o` are 0.
- R2: With `center_i`=0 the counter takes the values 0 to P-1 once per period, one value per enabled tick (P is the captured period). `pwm_o` is 1 exactly when the counter value is at least the captured duty D, so each period has P-D trailing active ticks. The first counter value 0 becomes visible in the cycle after the clock edge that samples `en_i`=1.
- R3: With `center_i`=1 the counter counts up from 0 to P-1 and then down from P to 1, so a period spans 2×P ticks. `pwm_o` is 1 when the value is at least D while counting up, and when the value exceeds D while counting down, which gives 2×(P-D) active ticks per period.
- R4: D=0 gives an output that is always active while enabled, and D≥P gives an output that is always inactive, in both modes.
- R5: `evt_o` is 1 for exactly one master-clock cycle: the cycle in which the counter has just returned to 0 at the end of a period. It does not pulse at the start of the first period after enabling.
- R6: `period_i`, `duty_i` and `center_i` are captured when the channel is enabled and again at every period boundary. A change in the middle of a period first affects the next period.
- R7: When `en_i` is 0 at a clock edge, `pwm_o` and `evt_o` are 0 in the following cycle and the counter returns to 0. Enabling again starts a fresh period.
- R8: `clk_sel_i` values 0 to 10 advance the counter once every 2^`clk_sel_i` master-clock cycles.
- R9: `clk_sel_i`=11 advances the counter only in cycles where `ext_a_i` is 1. `clk_sel_i`=12 does the same with `ext_b_i`.
- R10: `clk_sel_i` values 13 to 15 select no enable, so the counter is frozen and `evt_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Channel enable |
| center_i | input | 1 | 1 = symmetric up/down counting, 0 = edge-aligned up counting |
| clk_sel_i | input | 4 | Counter enable select: 0..10 prescaler taps, 11 external A, 12 external B |
| period_i | input | 16 | Period value P in counter ticks (half-period in symmetric mode), at least 1 |
| duty_i | input | 16 | Inactive length D in counter ticks |
| ext_a_i | input | 1 | External divided-clock enable A |
| ext_b_i | input | 1 | External divided-clock enable B |
| pwm_o | output | 1 | Waveform output, active high |
| evt_o | output | 1 | Single-cycle period-boundary pulse |

## Verification
Both outputs come only from registers. Any stimulus sampled at a master-clock edge therefore appears in the very next cycle: a new counter state, a level change, an event pulse or the disabled state. The scoreboard driver queues one expected (level, event) pair per cycle, starting right after the edge that takes the enable. The monitor compares them at each falling edge, half a cycle after the result became due. For slow enables, the bench measures whole periods between two event pulses in master-clock cycles and counts the active cycles. This makes those checks independent of the free-running prescaler's phase.

// File: rtl/pwm_cmp_pkg.sv
// Shared definitions for the aligned PWM channel.
// Assumes: clock select codes above the prescaler taps pick the external
// enables in a fixed order (first A, then B).
package pwm_cmp_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;
endpackage

// File: rtl/pwm_prescaler.sv
// Free-running prescaler. Produces PRE_W+1 single-cycle enable taps; tap k
// fires once every 2^k master-clock cycles (tap 0 on every cycle).
// Assumes: taps are consumed as clock enables on the same clock.
module pwm_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PRE_W:0]   tap_o
);
    logic [PRE_W-1:0] div_q;

    // Advance the free-running divider every master-clock cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tap_o[0] = 1'b1;
    for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
        // Tap k fires when the low k divider bits are all ones.
        assign tap_o[k] = &div_q[k-1:0];
    end

    // The divide-by-two tap never fires on two consecutive cycles.
    assert_tap_alternates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o[1] |=> !tap_o[1]);
endmodule

// File: rtl/pwm_clk_sel.sv
// Counter-enable selector. Codes 0..PRE_W pick a prescaler tap, PRE_W+1 the
// external enable A, PRE_W+2 the external enable B; other codes give none.
// Assumes: external enables are synchronous single-cycle strobes.
module pwm_clk_sel #(
    parameter int PRE_W = 10,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W:0]   tap_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             ext_a_i,
    input  logic             ext_b_i,
    output logic             tick_o
);
    localparam int CODE_A = PRE_W + 1;
    localparam int CODE_B = PRE_W + 2;

    // Route the selected source to the counter enable.
    always_comb begin
        tick_o = 1'b0;
        for (int k = 0; k <= PRE_W; k++) begin
            if (sel_i == SEL_W'(k)) tick_o = tap_i[k];
        end
        if (sel_i == SEL_W'(CODE_A)) tick_o = ext_a_i;
        if (sel_i == SEL_W'(CODE_B)) tick_o = ext_b_i;
    end

    // Unused codes never produce an enable.
    assert_no_tick_unused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_i) > CODE_B) |-> !tick_o);
endmodule

// File: rtl/pwm_wave_core.sv
// Channel counter and comparator. Holds shadow copies of period, duty and
// mode, loaded at enable and at each period boundary, and advances the
// counter on the selected tick. Output: active when counter >= duty while
// counting up, counter > duty while counting down.
// Assumes: period value is at least 1.
module pwm_wave_core
    import pwm_cmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          center_i,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] duty_i,
    input  logic          tick_i,
    output logic          pwm_o,
    output logic          evt_o
);
    logic          en_q;
    logic          align_q;
    logic [CW-1:0] prd_q;
    logic [CW-1:0] dty_q;
    logic [CW-1:0] cnt_q;
    cnt_dir_e      dir_q;
    logic          evt_q;

    logic [CW:0]   cnt_inc;
    logic          last_up;
    logic          adv;
    logic          wrap;
    logic [CW-1:0] cnt_n;
    cnt_dir_e      dir_n;

    assign cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
    assign last_up = (cnt_inc >= {1'b0, prd_q});
    assign adv     = en_q & en_i & tick_i;

    // Next counter value and direction for one enabled tick.
    always_comb begin
        wrap  = 1'b0;
        cnt_n = cnt_q;
        dir_n = dir_q;
        if (!align_q) begin
            if (last_up) begin
                wrap  = 1'b1;
                cnt_n = '0;
            end else begin
                cnt_n = cnt_inc[CW-1:0];
            end
        end else if (dir_q == DIR_UP) begin
            if (last_up) begin
                cnt_n = prd_q;
                dir_n = DIR_DOWN;
            end else begin
                cnt_n = cnt_inc[CW-1:0];
            end
        end else if (cnt_q <= CW'(1)) begin
            wrap  = 1'b1;
            cnt_n = '0;
            dir_n = DIR_UP;
        end else begin
            cnt_n = cnt_q - CW'(1);
        end
    end

    // Channel state: idle when disabled, shadow load at start, count on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            align_q <= 1'b0;
            prd_q   <= '0;
            dty_q   <= '0;
            cnt_q   <= '0;
            dir_q   <= DIR_UP;
            evt_q   <= 1'b0;
        end else if (!en_i) begin
            en_q    <= 1'b0;
            cnt_q   <= '0;
            dir_q   <= DIR_UP;
            evt_q   <= 1'b0;
        end else begin
            en_q  <= 1'b1;
            evt_q <= adv & wrap;
            if (!en_q || (adv && wrap)) begin
                align_q <= center_i;
                prd_q   <= period_i;
                dty_q   <= duty_i;
            end
            if (!en_q) begin
                cnt_q <= '0;
                dir_q <= DIR_UP;
            end else if (adv) begin
                cnt_q <= cnt_n;
                dir_q <= dir_n;
            end
        end
    end

    // Compare counter with duty; direction decides the tie at the threshold.
    assign pwm_o = en_q & ((dir_q == DIR_DOWN) ? (cnt_q > dty_q) : (cnt_q >= dty_q));
    assign evt_o = evt_q;

    assert_disable_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!pwm_o && !evt_o && cnt_q == '0));
    assert_evt_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (cnt_q == '0 && dir_q == DIR_UP));
    assert_left_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !align_q && prd_q != '0) |-> (cnt_q < prd_q && dir_q == DIR_UP));
    assert_center_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && align_q) |-> (cnt_q <= prd_q));
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && !evt_o) |->
            ($stable(prd_q) && $stable(dty_q) && $stable(align_q)));
endmodule

// File: rtl/pwm_aligned_channel.sv
// Single PWM channel: prescaler, enable selector and wave core.
// Assumes: all inputs are synchronous to clk; period_i >= 1.
module pwm_aligned_channel #(
    parameter int CW    = 16,
    parameter int PRE_W = 10,
    parameter int SEL_W = $clog2(PRE_W + 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             center_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    input  logic [CW-1:0]    period_i,
    input  logic [CW-1:0]    duty_i,
    input  logic             ext_a_i,
    input  logic             ext_b_i,
    output logic             pwm_o,
    output logic             evt_o
);
    logic [PRE_W:0] tap;
    logic           tick;

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tap_o (tap)
    );

    pwm_clk_sel #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_i   (tap),
        .sel_i   (clk_sel_i),
        .ext_a_i (ext_a_i),
        .ext_b_i (ext_b_i),
        .tick_o  (tick)
    );

    pwm_wave_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .center_i (center_i),
        .period_i (period_i),
        .duty_i   (duty_i),
        .tick_i   (tick),
        .pwm_o    (pwm_o),
        .evt_o    (evt_o)
    );
endmodule

// File: tb/sim_pwm_aligned_channel.sv
module sim_pwm_aligned_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        center_i = 1'b0;
    logic [3:0]  clk_sel_i = 4'd0;
    logic [15:0] period_i = 16'd1;
    logic [15:0] duty_i = 16'd0;
    logic        ext_a_i = 1'b0;
    logic        ext_b_i = 1'b0;
    logic        pwm_o;
    logic        evt_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic  lvl;
        logic  evt;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    pwm_aligned_channel u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .center_i(center_i),
        .clk_sel_i(clk_sel_i), .period_i(period_i), .duty_i(duty_i),
        .ext_a_i(ext_a_i), .ext_b_i(ext_b_i), .pwm_o(pwm_o), .evt_o(evt_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // External enables: A every 3rd cycle, B every 5th cycle.
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            ext_a_i = (k % 3 == 0);
            ext_b_i = (k % 5 == 0);
            k++;
        end
    end

    // Monitor: pop one expected item per cycle and compare.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(pwm_o === e.lvl, {e.tag, " level"}, int'(pwm_o), int'(e.lvl));
            check(evt_o === e.evt, {e.tag, " event"}, int'(evt_o), int'(e.evt));
        end
    end

    // Driver helper: queue one period of expected cycles (tick every cycle).
    task automatic push_period(input bit ctr, input int p, input int d, input bit first, input string tag);
        int len = ctr ? 2 * p : p;
        for (int i = 0; i < len; i++) begin
            exp_t e;
            int v;
            if (!ctr || i < p) begin
                v = i;
                e.lvl = (v >= d);
            end else begin
                v = 2 * p - i;
                e.lvl = (v > d);
            end
            e.evt = (i == 0) && !first;
            e.tag = tag;
            sb_q.push_back(e);
        end
    endtask

    task automatic push_const(input logic lvl, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.lvl = lvl; e.evt = 1'b0; e.tag = tag;
            sb_q.push_back(e);
        end
    endtask

    // Apply settings at a falling edge and wait for the capturing edge.
    task automatic start(input bit ctr, input int sel, input int p, input int d);
        center_i = ctr; clk_sel_i = 4'(sel);
        period_i = 16'(p); duty_i = 16'(d); en_i = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        en_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Measure one whole period between event pulses, in master-clock cycles.
    task automatic measure(input int exp_len, input int exp_hi, input string tag);
        int c = 0;
        int h = 0;
        int w = 0;
        while (!evt_o && w < 5000) begin
            @(negedge clk); w++;
        end
        h = pwm_o ? 1 : 0;
        forever begin
            @(negedge clk); c++;
            if (evt_o || c > 5000) break;
            if (pwm_o) h++;
        end
        check(c == exp_len, {tag, " period cycles"}, c, exp_len);
        check(h == exp_hi, {tag, " active cycles"}, h, exp_hi);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: outputs low in reset and right after release.
        repeat (3) @(negedge clk);
        check(pwm_o === 1'b0 && evt_o === 1'b0, "R1 during reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_o === 1'b0 && evt_o === 1'b0, "R1 after reset", int'(pwm_o), 0);

        // R2/R5: edge-aligned P=5 D=2, three periods.
        @(negedge clk);
        start(1'b0, 0, 5, 2);
        push_period(0, 5, 2, 1, "R2 left p5d2");
        push_period(0, 5, 2, 0, "R5 left p5d2");
        push_period(0, 5, 2, 0, "R2 left p5d2");
        repeat (15) @(negedge clk);
        idle(2);

        // R4: duty 0 always active, duty beyond period always inactive.
        start(1'b0, 0, 4, 0);
        push_period(0, 4, 0, 1, "R4 left d0");
        push_period(0, 4, 0, 0, "R4 left d0");
        repeat (8) @(negedge clk);
        idle(2);
        start(1'b0, 0, 4, 6);
        push_period(0, 4, 6, 1, "R4 left d>p");
        push_period(0, 4, 6, 0, "R4 left d>p");
        repeat (8) @(negedge clk);
        idle(2);

        // R3: symmetric P=4 D=1, two periods; R4 in symmetric mode.
        start(1'b1, 0, 4, 1);
        push_period(1, 4, 1, 1, "R3 center p4d1");
        push_period(1, 4, 1, 0, "R3 center p4d1");
        repeat (16) @(negedge clk);
        idle(2);
        start(1'b1, 0, 3, 0);
        push_period(1, 3, 0, 1, "R4 center d0");
        repeat (6) @(negedge clk);
        idle(2);

        // R6: change period/duty mid-period; takes effect at next boundary.
        start(1'b0, 0, 6, 3);
        push_period(0, 6, 3, 1, "R6 old");
        push_period(0, 6, 3, 0, "R6 old");
        push_period(0, 3, 1, 0, "R6 new");
        push_period(0, 3, 1, 0, "R6 new");
        repeat (8) @(negedge clk);
        period_i = 16'd3; duty_i = 16'd1;
        repeat (10) @(negedge clk);
        idle(2);

        // R7: disable mid-period, idle, then re-enable from a fresh period.
        start(1'b0, 0, 4, 2);
        push_period(0, 4, 2, 1, "R7 run");
        push_period(0, 4, 2, 0, "R7 run");
        sb_q.pop_back(); sb_q.pop_back();
        push_const(1'b0, 2, "R7 disabled");
        push_period(0, 4, 2, 1, "R7 restart");
        repeat (6) @(negedge clk);
        en_i = 1'b0;
        repeat (2) @(negedge clk);
        en_i = 1'b1;
        repeat (4) @(negedge clk);
        idle(2);

        // R8: prescaler taps.
        start(1'b0, 2, 3, 1);
        measure(12, 8, "R8 div4 left");
        idle(2);
        start(1'b1, 1, 3, 1);
        measure(12, 8, "R8 div2 center");
        idle(2);

        // R9: external enables.
        start(1'b0, 11, 4, 1);
        measure(12, 9, "R9 ext A left");
        idle(2);
        start(1'b1, 12, 2, 1);
        measure(20, 10, "R9 ext B center");
        idle(2);

        // R10: unused select code freezes the counter, no events.
        start(1'b0, 13, 3, 0);
        begin
            int ev = 0;
            int lo = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (evt_o) ev++;
                if (!pwm_o) lo++;
            end
            check(ev == 0, "R10 no events", ev, 0);
            check(lo == 0, "R10 frozen at zero", lo, 0);
        end
        idle(2);

        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule